// File: doc/BRIEF.md
# Hot-Swap Channel Fault Sequencer

This block sequences one hot-swap power channel from digitized comparator flags. It turns an external pass transistor on through a timed soft-start, watches for three grades of overcurrent while the channel runs, and decides when to give up and shut the gate. All timing comes from one cycle counter, so the soft-start deadline and the current-regulation time limit are both a fixed number of clock cycles (`PERIOD`).

After a timeout the channel either stays off until enable is cycled (latch mode) or sits in a cool-down of `RETRY_PERIODS` full counter periods and then tries a fresh soft-start. It repeats this for as long as the fault persists. A status count shows how many cool-down periods have completed. Every input flag passes through a two-flop synchronizer, and every output is a flop.

Top module: `hotswap_seq`

## Requirements
- R1: While `rst` is high or the synchronized `supply_ok` is low, the block is held idle. In that state `gate_cmd`=0 (off), `ss_run`=0, `fault_n`=1, `pgood_n`=1, `retry_cnt`=0 and the timer is cleared.
- R2: A level applied to any input before rising edge k is acted on at edge k+2. The outputs show the result right after edge k+2.
- R3: With the channel idle, a low `en_n` starts soft-start: `gate_cmd`=1 (ramp), `ss_run`=1, and the timer counts from zero. A high `en_n` sends every other state to idle (`gate_cmd`=0, `ss_run`=0, `fault_n`=1, `retry_cnt`=0). This has priority over every other flag.
- R4: If `out_near_in` is seen during soft-start, the gate goes to full-on (`gate_cmd`=4) with `fault_n`=1. This includes the last counted cycle, where it beats the deadline.
- R5: If soft-start lasts `PERIOD` cycles without `out_near_in`, all of these happen in the same cycle: `gate_cmd`=5 (hard pulldown), `ss_run`=0 and `fault_n`=0.
- R6: At full-on, `ovr_reg` moves the gate to regulate (`gate_cmd`=2) with the timer restarted from zero. If the flag clears in fewer than `PERIOD` cycles, the gate returns to full-on with no fault.
- R7: If regulation (regulate or weak pulldown) lasts `PERIOD` cycles, the block trips exactly as in R5.
- R8: `quick_slew` gives the weak pulldown (`gate_cmd`=3) from full-on or regulate. When it drops, the gate goes to regulate if `ovr_reg` is set, otherwise to full-on. The timer keeps running between regulate and weak pulldown.
- R9: At full-on, `severe_oc` gives hard pulldown for exactly one cycle. After that the gate goes to regulate if any overcurrent flag is still set, otherwise back to full-on. `fault_n` stays 1.
- R10: With `latch_mode`=1 at the trip, the gate holds hard pulldown and `fault_n`=0 until `en_n` goes high. Only a later low `en_n` starts a new soft-start.
- R11: With `latch_mode`=0 at the trip, the gate holds hard pulldown and `retry_cnt` counts completed periods from 0. When the 64th period ends, which is 64·`PERIOD` cycles after the trip, `retry_cnt`=64 and soft-start restarts with `fault_n` still 0. A restart that times out goes back to the cool-down with `retry_cnt`=0. This continues without limit.
- R12: A restart that reaches full-on clears `fault_n` to 1 and `retry_cnt` to 0.
- R13: `pgood_n` is the inverse of the synchronized `uv_good` in every non-idle-held state, whatever the gate is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply-ready flag; low holds the block idle |
| en_n | input | 1 | Channel enable, active low |
| ovr_reg | input | 1 | Load current at or above the regulation level |
| quick_slew | input | 1 | Current 20% or more above the regulation level |
| severe_oc | input | 1 | Current near three times the regulation level |
| out_near_in | input | 1 | Output within 100 mV of input |
| uv_good | input | 1 | Output above the undervoltage threshold |
| latch_mode | input | 1 | 1 = latch off after a timeout, 0 = counted auto-retry |
| gate_cmd | output | 3 | 0 off, 1 ramp, 2 regulate, 3 weak pulldown, 4 full-on, 5 hard pulldown |
| ss_run | output | 1 | 1 lets soft-start charge, 0 discharges it |
| fault_n | output | 1 | Fault flag, active low |
| pgood_n | output | 1 | Power good, active low |
| retry_cnt | output | $clog2(RETRY_PERIODS+1) | Completed cool-down periods (0 to RETRY_PERIODS) |

## Verification
Two functions can act on the same edge: the soft-start deadline expiring and the output reaching its input. The bench applies `out_near_in` so that its synchronized copy arrives on the very edge where the counter hits its last count. It expects full-on with no fault. The same stimulus one cycle later must give the trip instead. A second pairing checks that a high enable during the cool-down wins over a period expiring on the same edge. A reference model compares all outputs on every cycle, so a wrong winner shows up in the first cycle after that edge.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [2:0] {
    GATE_OFF  = 3'd0,
    GATE_RAMP = 3'd1,
    GATE_REG  = 3'd2,
    GATE_WEAK = 3'd3,
    GATE_FULL = 3'd4,
    GATE_HARD = 3'd5
  } gate_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAMP,
    ST_RUN,
    ST_LIMIT,
    ST_SLEW,
    ST_KICK,
    ST_HOLD,
    ST_COOL
  } st_e;

  typedef struct packed {
    logic ready;
    logic en_n;
    logic ovr;
    logic slew;
    logic severe;
    logic near;
    logic uvok;
    logic latch;
  } flags_t;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_timer.sv
module hs_timer #(
  parameter int PERIOD = 16
) (
  input  logic clk,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (clr)          cnt <= '0;
    else if (expired) cnt <= '0;
    else if (run)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hs_fsm.sv
module hs_fsm
  import hs_pkg::*;
#(
  parameter int RETRY_PERIODS = 64,
  localparam int RCW = $clog2(RETRY_PERIODS + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  flags_t         f,
  input  logic           expired,
  output logic           tmr_run,
  output logic           tmr_clr,
  output logic [2:0]     gate_cmd,
  output logic           ss_run,
  output logic           fault_n,
  output logic           pgood_n,
  output logic [RCW-1:0] retry_cnt
);
  localparam logic [RCW-1:0] RC_LAST = RCW'(RETRY_PERIODS - 1);
  localparam logic [RCW-1:0] RC_FULL = RCW'(RETRY_PERIODS);

  st_e            st_q, st_d;
  logic           flt_q, flt_d;
  logic [RCW-1:0] rc_q, rc_d;
  logic           hold, any_oc;

  function automatic gate_e gate_of(st_e s);
    case (s)
      ST_RAMP:  return GATE_RAMP;
      ST_RUN:   return GATE_FULL;
      ST_LIMIT: return GATE_REG;
      ST_SLEW:  return GATE_WEAK;
      ST_KICK, ST_HOLD, ST_COOL: return GATE_HARD;
      default:  return GATE_OFF;
    endcase
  endfunction

  function automatic logic ss_of(st_e s);
    return (s == ST_RAMP) || (s == ST_RUN) || (s == ST_LIMIT) ||
           (s == ST_SLEW) || (s == ST_KICK);
  endfunction

  assign hold    = rst | ~f.ready;
  assign any_oc  = f.ovr | f.slew | f.severe;
  assign tmr_run = (st_q == ST_RAMP) || (st_q == ST_LIMIT) ||
                   (st_q == ST_SLEW) || (st_q == ST_COOL);
  assign tmr_clr = hold | ~tmr_run;

  always_comb begin
    st_d  = st_q;
    flt_d = flt_q;
    rc_d  = rc_q;
    if (f.en_n) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: st_d = ST_RAMP;
        ST_RAMP: begin
          if (f.near) begin
            st_d  = ST_RUN;
            flt_d = 1'b0;
            rc_d  = '0;
          end else if (expired) begin
            st_d  = f.latch ? ST_HOLD : ST_COOL;
            flt_d = 1'b1;
            rc_d  = '0;
          end
        end
        ST_RUN: begin
          if (f.severe)    st_d = ST_KICK;
          else if (f.slew) st_d = ST_SLEW;
          else if (f.ovr)  st_d = ST_LIMIT;
        end
        ST_KICK: st_d = any_oc ? ST_LIMIT : ST_RUN;
        ST_LIMIT, ST_SLEW: begin
          if (expired) begin
            st_d  = f.latch ? ST_HOLD : ST_COOL;
            flt_d = 1'b1;
            rc_d  = '0;
          end else if (f.slew || f.severe) begin
            st_d = ST_SLEW;
          end else if (f.ovr) begin
            st_d = ST_LIMIT;
          end else begin
            st_d = ST_RUN;
          end
        end
        ST_HOLD: st_d = ST_HOLD;
        ST_COOL: begin
          if (expired) begin
            if (rc_q == RC_LAST) begin
              st_d = ST_RAMP;
              rc_d = RC_FULL;
            end else begin
              rc_d = rc_q + 1'b1;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
    if (st_d == ST_IDLE) begin
      flt_d = 1'b0;
      rc_d  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (hold) begin
      st_q      <= ST_IDLE;
      flt_q     <= 1'b0;
      rc_q      <= '0;
      gate_cmd  <= GATE_OFF;
      ss_run    <= 1'b0;
      fault_n   <= 1'b1;
      pgood_n   <= 1'b1;
      retry_cnt <= '0;
    end else begin
      st_q      <= st_d;
      flt_q     <= flt_d;
      rc_q      <= rc_d;
      gate_cmd  <= gate_of(st_d);
      ss_run    <= ss_of(st_d);
      fault_n   <= ~flt_d;
      pgood_n   <= ~f.uvok;
      retry_cnt <= rc_d;
    end
  end
endmodule

// File: rtl/hotswap_seq.sv
module hotswap_seq #(
  parameter int PERIOD = 16,
  parameter int RETRY_PERIODS = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic en_n,
  input  logic ovr_reg,
  input  logic quick_slew,
  input  logic severe_oc,
  input  logic out_near_in,
  input  logic uv_good,
  input  logic latch_mode,
  output logic [2:0] gate_cmd,
  output logic ss_run,
  output logic fault_n,
  output logic pgood_n,
  output logic [$clog2(RETRY_PERIODS+1)-1:0] retry_cnt
);
  localparam int FW = $bits(hs_pkg::flags_t);
  localparam hs_pkg::flags_t SYNC_RST = '{ready: 1'b0, en_n: 1'b1, ovr: 1'b0,
                                          slew: 1'b0, severe: 1'b0, near: 1'b0,
                                          uvok: 1'b0, latch: 1'b1};

  hs_pkg::flags_t raw, synced;
  logic           expired, tmr_run, tmr_clr;

  assign raw = '{ready: supply_ok, en_n: en_n, ovr: ovr_reg, slew: quick_slew,
                 severe: severe_oc, near: out_near_in, uvok: uv_good,
                 latch: latch_mode};

  hs_sync #(.W(FW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (synced)
  );

  hs_timer #(.PERIOD(PERIOD)) u_timer (
    .clk     (clk),
    .clr     (tmr_clr),
    .run     (tmr_run),
    .expired (expired)
  );

  hs_fsm #(.RETRY_PERIODS(RETRY_PERIODS)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .f         (synced),
    .expired   (expired),
    .tmr_run   (tmr_run),
    .tmr_clr   (tmr_clr),
    .gate_cmd  (gate_cmd),
    .ss_run    (ss_run),
    .fault_n   (fault_n),
    .pgood_n   (pgood_n),
    .retry_cnt (retry_cnt)
  );
endmodule

// File: rtl/hs_seq_chk.sv
module hs_seq_chk #(
  parameter int RETRY_PERIODS = 64
) (
  input logic clk,
  input logic rst,
  input logic [2:0] gate_cmd,
  input logic ss_run,
  input logic fault_n,
  input logic pgood_n,
  input logic [$clog2(RETRY_PERIODS+1)-1:0] retry_cnt
);
  import hs_pkg::*;

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (gate_cmd == GATE_OFF && !ss_run && fault_n && pgood_n && retry_cnt == 0)); // R1

  AST_NEAR_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (gate_cmd == GATE_FULL) |-> (fault_n && ss_run)); // R4

  AST_TRIP_ACTIONS: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_n) |-> (gate_cmd == GATE_HARD && !ss_run)); // R5

  AST_KICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (gate_cmd == GATE_HARD && fault_n) |=> (gate_cmd != GATE_HARD)); // R9

  AST_FAULT_GATE: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> (gate_cmd == GATE_HARD || gate_cmd == GATE_RAMP)); // R10

  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst)
    retry_cnt <= RETRY_PERIODS); // R11

  AST_RETRY_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(retry_cnt) |-> (retry_cnt == 0 || retry_cnt == $past(retry_cnt) + 1)); // R11

  AST_RETRY_RESTART: assert property (@(posedge clk) disable iff (rst)
    ($past(retry_cnt) == RETRY_PERIODS - 1 && retry_cnt == RETRY_PERIODS)
      |-> (gate_cmd == GATE_RAMP && !fault_n)); // R11
endmodule

bind hotswap_seq hs_seq_chk #(.RETRY_PERIODS(RETRY_PERIODS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .gate_cmd  (gate_cmd),
  .ss_run    (ss_run),
  .fault_n   (fault_n),
  .pgood_n   (pgood_n),
  .retry_cnt (retry_cnt)
);

// File: tb/hotswap_seq_tb.sv
module hotswap_seq_tb;
  localparam int P  = 16;
  localparam int NR = 64;
  localparam int RW = $clog2(NR + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0, en_n = 1'b1, ovr = 1'b0, qs = 1'b0, sev = 1'b0;
  logic near = 1'b0, uvg = 1'b0, lmode = 1'b1;
  logic [2:0]    gate_cmd;
  logic          ss_run, fault_n, pgood_n;
  logic [RW-1:0] retry_cnt;

  int errors = 0, checks = 0, cyc = 0;

  hotswap_seq #(.PERIOD(P), .RETRY_PERIODS(NR), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .en_n(en_n), .ovr_reg(ovr),
    .quick_slew(qs), .severe_oc(sev), .out_near_in(near), .uv_good(uvg),
    .latch_mode(lmode), .gate_cmd(gate_cmd), .ss_run(ss_run), .fault_n(fault_n),
    .pgood_n(pgood_n), .retry_cnt(retry_cnt)
  );

  always #5 clk = ~clk;

  // Reference model. Bits: 7 ready 6 en_n 5 ovr 4 slew 3 severe 2 near 1 uv 0 latch
  localparam logic [7:0] DEF = 8'b0100_0001;
  logic [7:0] h1, h2, fv;
  int ms, mc, mrc, mg;
  bit mflt, mss, mpg, cnting, tmo, anyoc;
  int gmap [8] = '{0, 1, 4, 2, 3, 5, 5, 5};

  task automatic m_idle();
    ms = 0; mc = 0; mrc = 0; mflt = 0; mg = 0; mss = 0; mpg = 1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      h1 = DEF; h2 = DEF; m_idle();
    end else begin
      fv = h2; h2 = h1; h1 = {supply_ok, en_n, ovr, qs, sev, near, uvg, lmode};
      if (!fv[7]) m_idle();
      else begin
        cnting = (ms == 1 || ms == 3 || ms == 4 || ms == 7);
        tmo    = cnting && (mc == P - 1);
        mc     = (!cnting || tmo) ? 0 : mc + 1;
        anyoc  = fv[5] | fv[4] | fv[3];
        if (fv[6]) ms = 0;
        else if (ms == 0) ms = 1;
        else if (ms == 1) begin
          if (fv[2]) begin ms = 2; mflt = 0; mrc = 0; end
          else if (tmo) begin ms = fv[0] ? 6 : 7; mflt = 1; mrc = 0; end
        end else if (ms == 2) begin
          if (fv[3]) ms = 5; else if (fv[4]) ms = 4; else if (fv[5]) ms = 3;
        end else if (ms == 5) ms = anyoc ? 3 : 2;
        else if (ms == 3 || ms == 4) begin
          if (tmo) begin ms = fv[0] ? 6 : 7; mflt = 1; mrc = 0; end
          else if (fv[4] | fv[3]) ms = 4;
          else if (fv[5]) ms = 3;
          else ms = 2;
        end else if (ms == 7 && tmo) begin
          if (mrc == NR - 1) begin ms = 1; mrc = NR; end
          else mrc++;
        end
        if (ms == 0) begin mflt = 0; mrc = 0; end
        mg  = gmap[ms];
        mss = (ms >= 1 && ms <= 5);
        mpg = !fv[1];
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (gate_cmd != mg[2:0] || ss_run != mss || fault_n != !mflt ||
        pgood_n != mpg || retry_cnt != RW'(mrc)) begin
      errors++;
      $display("FAIL R3-model cyc=%0d act gate=%0d ss=%0d flt_n=%0d pg_n=%0d rc=%0d exp gate=%0d ss=%0d flt_n=%0d pg_n=%0d rc=%0d",
               cyc, gate_cmd, ss_run, fault_n, pgood_n, retry_cnt,
               mg, mss, !mflt, mpg, mrc);
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d cycles exp=finish", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d cyc=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic recycle_en();
    en_n = 1'b1; step(4); en_n = 1'b0; step(3);
  endtask

  int t0, t1, n;

  initial begin
    step(4);
    chk("R1 gate in reset", gate_cmd, 0);
    chk("R1 fault_n in reset", fault_n, 1);
    chk("R1 pgood_n in reset", pgood_n, 1);
    rst = 1'b0; en_n = 1'b0; uvg = 1'b1; step(5);
    chk("R1 supply low holds idle", gate_cmd, 0);
    chk("R1 supply low holds ss", ss_run, 0);
    supply_ok = 1'b1; step(2);
    chk("R2 two edges not yet", gate_cmd, 0);
    step(1);
    chk("R2 third edge ramp", gate_cmd, 1);
    chk("R3 ss runs", ss_run, 1);
    chk("R13 pgood follows", pgood_n, 0);
    uvg = 1'b0; step(3);
    chk("R13 pgood drops", pgood_n, 1);
    // soft-start times out, latch mode
    step(P);
    chk("R5 trip gate", gate_cmd, 5);
    chk("R5 trip ss", ss_run, 0);
    chk("R5 trip fault", fault_n, 0);
    step(40);
    chk("R10 still latched", gate_cmd, 5);
    en_n = 1'b1; step(4);
    chk("R10 released gate", gate_cmd, 0);
    chk("R10 released fault", fault_n, 1);
    en_n = 1'b0; step(3);
    chk("R10 re-ramp", gate_cmd, 1);
    near = 1'b1; step(4);
    chk("R4 full on", gate_cmd, 4);
    chk("R4 no fault", fault_n, 1);
    // R6 short regulation
    ovr = 1'b1; step(3);
    chk("R6 regulate", gate_cmd, 2);
    step(6); ovr = 1'b0; step(3);
    chk("R6 back to full", gate_cmd, 4);
    chk("R6 no fault", fault_n, 1);
    // R8 weak pulldown and return paths
    qs = 1'b1; step(3);
    chk("R8 weak", gate_cmd, 3);
    qs = 1'b0; ovr = 1'b1; step(1);
    step(2);
    chk("R8 back to regulate", gate_cmd, 2);
    ovr = 1'b0; step(3);
    chk("R8 back to full", gate_cmd, 4);
    // R9 one-cycle severe pulse
    sev = 1'b1; step(1); sev = 1'b0; step(2);
    chk("R9 hard one cycle", gate_cmd, 5);
    chk("R9 no fault", fault_n, 1);
    step(1);
    chk("R9 released", gate_cmd, 4);
    sev = 1'b1; step(3); sev = 1'b0;
    chk("R9 held hard", gate_cmd, 5);
    step(1);
    chk("R9 timed regulation", gate_cmd, 2);
    step(4);
    chk("R9 recovered", gate_cmd, 4);
    // R8 timer continues across weak/regulate
    qs = 1'b1; step(10); qs = 1'b0; ovr = 1'b1; step(20);
    chk("R8 shared timer trips", gate_cmd, 5);
    chk("R8 shared timer fault", fault_n, 0);
    ovr = 1'b0; recycle_en(); step(4);
    chk("R4 full again", gate_cmd, 4);
    // R7 regulation timeout
    ovr = 1'b1; step(P + 4);
    chk("R7 trip gate", gate_cmd, 5);
    chk("R7 trip fault", fault_n, 0);
    ovr = 1'b0;
    // R4 corner: near on the deadline edge wins
    near = 1'b0; en_n = 1'b1; step(4);
    en_n = 1'b0;
    repeat (P) @(negedge clk);
    near = 1'b1; step(4);
    chk("R4 near on deadline edge", gate_cmd, 4);
    chk("R4 near on deadline fault", fault_n, 1);
    near = 1'b0; en_n = 1'b1; step(4);
    en_n = 1'b0;
    repeat (P + 1) @(negedge clk);
    near = 1'b1; step(4);
    chk("R5 near one late trips", gate_cmd, 5);
    near = 1'b0;
    // R3 enable wins over a running channel
    recycle_en(); near = 1'b1; step(4); near = 1'b0;
    en_n = 1'b1; step(3);
    chk("R3 disable gate", gate_cmd, 0);
    chk("R3 disable ss", ss_run, 0);
    // R11 counted retry
    lmode = 1'b0; en_n = 1'b0;
    n = 0;
    while (fault_n && n < 200) begin step(1); n++; end
    t0 = cyc;
    step(5 * P);
    chk("R11 periods counted", retry_cnt, 5);
    chk("R11 cooling gate", gate_cmd, 5);
    n = 0;
    while (gate_cmd != 3'd1 && n < 3000) begin step(1); n++; end
    t1 = cyc;
    chk("R11 restart delay", t1 - t0, NR * P);
    chk("R11 count at restart", retry_cnt, NR);
    chk("R11 fault held on restart", fault_n, 0);
    step(P);
    chk("R11 failed retry cools", gate_cmd, 5);
    chk("R11 failed retry count", retry_cnt, 0);
    // enable high on a period-ending edge wins
    n = 0;
    while (retry_cnt != RW'(2) && n < 200) begin step(1); n++; end
    step(P - 3); en_n = 1'b1; step(3);
    chk("R3 disable beats period end", gate_cmd, 0);
    chk("R3 disable clears count", retry_cnt, 0);
    en_n = 1'b0;
    n = 0;
    while (fault_n && n < 200) begin step(1); n++; end
    n = 0;
    while (gate_cmd != 3'd1 && n < 3000) begin step(1); n++; end
    near = 1'b1; step(4);
    chk("R12 retry succeeds", gate_cmd, 4);
    chk("R12 fault cleared", fault_n, 1);
    chk("R12 count cleared", retry_cnt, 0);
    // R1 supply drop
    supply_ok = 1'b0; step(3);
    chk("R1 supply drop gate", gate_cmd, 0);
    chk("R1 supply drop ss", ss_run, 0);
    step(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule